// File: doc/BRIEF.md
# Forwarding Synchronous Register File

This block is the operand store of an in-order pipeline. It holds 64 entries of 64 bits. Entries 0 to 31 are the integer registers and entries 32 to 63 are the floating-point registers, and a single 6-bit index selects any of them. There is one write port and three read ports (A, B, C). Every read is registered, so the storage can be built from block RAM. The decode stage therefore hands over its read indices one stage before the operands are consumed.

The indices are captured on every clock edge. While the pipeline is stalled, the captured indices are read again, so the operands stay valid. The write index and data are also captured. Each read port compares its captured index against the captured write index. On a match it returns the captured write data in place of the array output, so a result written in one cycle is seen by a read issued in that same cycle.

A debug requester can read any entry through port B. It does so only in cycles when the pipeline leaves that port idle: no stall, and either no valid instruction or an instruction that does not use its B operand. A request waits until such a cycle arrives. The data is then returned with a one-cycle done strobe.

Top module: `fwd_regfile`

## Requirements
- R1: Reads are synchronous. An index presented in a cycle yields its data on the read port after the next rising clock edge, and the read outputs never change between edges.
- R2: A write with `wr_en` high commits `wr_data` to entry `wr_idx` at the rising edge. Any later read of that entry returns it.
- R3: If a read index presented in a cycle equals the write index presented with `wr_en` high in that same cycle, the port returns the new write data after the edge.
- R4: While `stall` is high, the indices captured at the previous edge are read again and the new index inputs are ignored. A write to the held entry during the stall is still forwarded.
- R5: A debug read takes port B only in a cycle where `stall` is low and either `dec_valid` is low or `dec_uses_b` is low. In any other cycle, port B returns the pipeline's own operand and `dbg_done` stays low the following cycle.
- R6: A debug request stays pending until port B is free. One cycle after it is issued, `dbg_done` is high for exactly that cycle, and `dbg_data` holds the content of entry `dbg_idx` as captured with the request. A request made while another is pending is ignored.
- R7: Reset clears the captured indices, the forwarding-valid flag, the pending debug request and `dbg_done`. It leaves the array contents unchanged.
- R8: All 64 entries are distinct storage. Entry n and entry n+32 (integer and floating-point register of the same number) hold independent values.
- R9: A debug read on port B does not disturb the data returned on ports A and C in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Pipeline stall: reuse the captured read indices |
| dec_valid | input | 1 | Decode stage holds a valid instruction |
| dec_uses_b | input | 1 | That instruction reads its B operand |
| raddr_a | input | 6 | Read index, port A |
| raddr_b | input | 6 | Read index, port B |
| raddr_c | input | 6 | Read index, port C |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write data |
| dbg_req | input | 1 | Debug read request (one-cycle pulse) |
| dbg_idx | input | 6 | Entry read by the debug request |
| rdata_a | output | 64 | Read data, port A |
| rdata_b | output | 64 | Read data, port B |
| rdata_c | output | 64 | Read data, port C |
| dbg_done | output | 1 | Debug data valid, one-cycle strobe |
| dbg_data | output | 64 | Debug read result |

## Verification
Read data is due exactly one rising edge after the index is presented. A debug result and its strobe are due one edge after the first free cycle that follows the request. Writes are visible on the ports after the edge that samples them. Both the reference model and the design outputs come only from registers. The inputs change at the falling edge, the reference model advances at the rising edge, and every comparison happens at the falling edge, half a period after the outputs settle. The directed checks step one falling edge per presented cycle and sample there, so each expected value lines up with the single edge of latency.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int unsigned NPORT  = 3;
    localparam int unsigned PORT_A = 0;
    localparam int unsigned PORT_B = 1;
    localparam int unsigned PORT_C = 2;
endpackage

// File: rtl/rf_array.sv
module rf_array #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned NPORT  = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr [NPORT],
    output logic [DATA_W-1:0] rdata [NPORT]
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Read-first: a read at the write edge returns the old word.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
        for (int p = 0; p < NPORT; p++) begin
            rdata[p] <= mem[raddr[p]];
        end
    end
endmodule

// File: rtl/rf_bypass.sv
module rf_bypass #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned IDX_W  = 6
) (
    input  logic [DATA_W-1:0] arr_data,
    input  logic [IDX_W-1:0]  rd_idx_q,
    input  logic              wr_vld_q,
    input  logic [IDX_W-1:0]  wr_idx_q,
    input  logic [DATA_W-1:0] wr_data_q,
    output logic [DATA_W-1:0] data
);
    logic hit;

    always_comb begin
        hit  = wr_vld_q && (rd_idx_q == wr_idx_q);
        data = hit ? wr_data_q : arr_data;
    end
endmodule

// File: rtl/rf_dbg_arb.sv
module rf_dbg_arb #(
    parameter int unsigned IDX_W = 6
) (
    input  logic             stall,
    input  logic             dec_valid,
    input  logic             dec_uses_b,
    input  logic             req,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             pend_q,
    input  logic [IDX_W-1:0] pidx_q,
    output logic             issue,
    output logic [IDX_W-1:0] eff_idx,
    output logic             pend_d,
    output logic [IDX_W-1:0] pidx_d
);
    logic port_free;
    logic wanting;

    always_comb begin
        port_free = !stall && (!dec_valid || !dec_uses_b);
        wanting   = pend_q || req;
        eff_idx   = pend_q ? pidx_q : req_idx;
        issue     = wanting && port_free;
        pend_d    = wanting && !issue;
        pidx_d    = eff_idx;
    end
endmodule

// File: rtl/fwd_regfile.sv
module fwd_regfile #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              dec_valid,
    input  logic              dec_uses_b,
    input  logic [IDX_W-1:0]  raddr_a,
    input  logic [IDX_W-1:0]  raddr_b,
    input  logic [IDX_W-1:0]  raddr_c,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              dbg_req,
    input  logic [IDX_W-1:0]  dbg_idx,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b,
    output logic [DATA_W-1:0] rdata_c,
    output logic              dbg_done,
    output logic [DATA_W-1:0] dbg_data
);
    import rf_pkg::*;

    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic [NPORT-1:0][IDX_W-1:0] hold;   // pipeline indices, reused on stall
        logic [NPORT-1:0][IDX_W-1:0] used;   // indices actually sent to the array
        logic                        wv;
        idx_t                        widx;
        logic [DATA_W-1:0]           wdat;
        logic                        pend;
        idx_t                        pidx;
        logic                        done;
    } st_t;

    st_t st_d, st_q;

    idx_t              in_idx  [NPORT];
    idx_t              arr_idx [NPORT];
    logic [DATA_W-1:0] arr_out [NPORT];
    logic [DATA_W-1:0] byp_out [NPORT];

    logic dbg_issue;
    idx_t dbg_eff;
    logic pend_nxt;
    idx_t pidx_nxt;
    logic pend_q;

    assign pend_q = st_q.pend;

    rf_dbg_arb #(.IDX_W(IDX_W)) u_arb (
        .stall      (stall),
        .dec_valid  (dec_valid),
        .dec_uses_b (dec_uses_b),
        .req        (dbg_req),
        .req_idx    (dbg_idx),
        .pend_q     (st_q.pend),
        .pidx_q     (st_q.pidx),
        .issue      (dbg_issue),
        .eff_idx    (dbg_eff),
        .pend_d     (pend_nxt),
        .pidx_d     (pidx_nxt)
    );

    always_comb begin
        in_idx[PORT_A] = raddr_a;
        in_idx[PORT_B] = raddr_b;
        in_idx[PORT_C] = raddr_c;

        st_d = st_q;
        for (int p = 0; p < NPORT; p++) begin
            st_d.hold[p] = stall ? st_q.hold[p] : in_idx[p];
            st_d.used[p] = st_d.hold[p];
        end
        if (dbg_issue) begin
            st_d.used[PORT_B] = dbg_eff;
        end
        for (int p = 0; p < NPORT; p++) begin
            arr_idx[p] = st_d.used[p];
        end

        st_d.wv   = wr_en;
        st_d.widx = wr_idx;
        st_d.wdat = wr_data;
        st_d.pend = pend_nxt;
        st_d.pidx = pidx_nxt;
        st_d.done = dbg_issue;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    rf_array #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NPORT(NPORT)) u_array (
        .clk   (clk),
        .we    (wr_en),
        .widx  (wr_idx),
        .wdata (wr_data),
        .raddr (arr_idx),
        .rdata (arr_out)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_byp
        rf_bypass #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_byp (
            .arr_data  (arr_out[g]),
            .rd_idx_q  (st_q.used[g]),
            .wr_vld_q  (st_q.wv),
            .wr_idx_q  (st_q.widx),
            .wr_data_q (st_q.wdat),
            .data      (byp_out[g])
        );
    end

    assign rdata_a  = byp_out[PORT_A];
    assign rdata_b  = byp_out[PORT_B];
    assign rdata_c  = byp_out[PORT_C];
    assign dbg_data = byp_out[PORT_B];
    assign dbg_done = st_q.done;
endmodule

// File: rtl/fwd_regfile_chk.sv
module fwd_regfile_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              dec_valid,
    input logic              dec_uses_b,
    input logic [IDX_W-1:0]  raddr_a,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              dbg_req,
    input logic [DATA_W-1:0] rdata_a,
    input logic              dbg_done,
    input logic              dbg_issue,
    input logic              pend_q
);
    p_fwd_same_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !stall && raddr_a == wr_idx) |=> (rdata_a == $past(wr_data)));

    p_stall_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !wr_en) |=> $stable(rdata_a));

    p_steal_when_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_issue |-> (!stall && (!dec_valid || !dec_uses_b)));

    p_busy_defers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stall || (dec_valid && dec_uses_b)) |=> !dbg_done);

    p_done_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_done |-> $past(dbg_req || pend_q));

    p_pending_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && stall) |=> pend_q);

    p_reset_quiet_r7: assert property (@(posedge clk)
        !rst_n |=> !dbg_done);
endmodule

bind fwd_regfile fwd_regfile_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .dec_valid  (dec_valid),
    .dec_uses_b (dec_uses_b),
    .raddr_a    (raddr_a),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .dbg_req    (dbg_req),
    .rdata_a    (rdata_a),
    .dbg_done   (dbg_done),
    .dbg_issue  (dbg_issue),
    .pend_q     (pend_q)
);

// File: tb/fwd_regfile_test.sv
module fwd_regfile_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;
    localparam int IW = 6;
    localparam int NE = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0, dec_valid = 1'b0, dec_uses_b = 1'b0;
    logic [IW-1:0] raddr_a = '0, raddr_b = '0, raddr_c = '0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic          dbg_req = 1'b0;
    logic [IW-1:0] dbg_idx = '0;
    logic [DW-1:0] rdata_a, rdata_b, rdata_c, dbg_data;
    logic          dbg_done;

    fwd_regfile #(.DATA_W(DW), .IDX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .dec_valid(dec_valid),
        .dec_uses_b(dec_uses_b), .raddr_a(raddr_a), .raddr_b(raddr_b),
        .raddr_c(raddr_c), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .dbg_req(dbg_req), .dbg_idx(dbg_idx), .rdata_a(rdata_a),
        .rdata_b(rdata_b), .rdata_c(rdata_c), .dbg_done(dbg_done),
        .dbg_data(dbg_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return {16'hC0DE, 8'(i), 40'(i * 40503 + 17)};
    endfunction

    // Behavioural reference model
    logic [DW-1:0] m_mem [NE];
    bit            m_def [NE];
    int            m_hold [3];
    int            m_out [3];
    bit            m_pend, m_done, m_live;
    int            m_pidx, m_daddr;

    initial begin
        for (int i = 0; i < NE; i++) m_def[i] = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 3; p++) begin m_hold[p] = 0; m_out[p] = 0; end
            m_pend = 0; m_done = 0; m_pidx = 0; m_live = 0;
        end else begin
            int  sel [3];
            int  in_a [3];
            bit  free, want, iss;
            int  eff;
            in_a[0] = int'(raddr_a); in_a[1] = int'(raddr_b); in_a[2] = int'(raddr_c);
            for (int p = 0; p < 3; p++) sel[p] = stall ? m_hold[p] : in_a[p];
            free = !stall && (!dec_valid || !dec_uses_b);
            want = m_pend || dbg_req;
            eff  = m_pend ? m_pidx : int'(dbg_idx);
            iss  = want && free;
            for (int p = 0; p < 3; p++) begin m_hold[p] = sel[p]; m_out[p] = sel[p]; end
            if (iss) m_out[1] = eff;
            m_pend  = want && !iss;
            m_pidx  = eff;
            m_done  = iss;
            m_daddr = eff;
            if (wr_en) begin m_mem[int'(wr_idx)] = wr_data; m_def[int'(wr_idx)] = 1; end
            m_live = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && m_live && !finished) begin
            if (m_def[m_out[0]]) chk(rdata_a === m_mem[m_out[0]], "R1 model port A", rdata_a, m_mem[m_out[0]]);
            if (m_def[m_out[1]]) chk(rdata_b === m_mem[m_out[1]], "R5 model port B", rdata_b, m_mem[m_out[1]]);
            if (m_def[m_out[2]]) chk(rdata_c === m_mem[m_out[2]], "R9 model port C", rdata_c, m_mem[m_out[2]]);
            chk(dbg_done === m_done, "R6 model done strobe", DW'(dbg_done), DW'(m_done));
            if (m_done && m_def[m_daddr])
                chk(dbg_data === m_mem[m_daddr], "R6 model debug data", dbg_data, m_mem[m_daddr]);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        // R7: reset
        repeat (3) step();
        chk(dbg_done === 1'b0, "R7 done low in reset", DW'(dbg_done), '0);
        rst_n = 1'b1;
        step();
        chk(dbg_done === 1'b0, "R7 done low after reset", DW'(dbg_done), '0);

        // fill every entry
        for (int i = 0; i < NE; i++) begin
            wr_en = 1'b1; wr_idx = IW'(i); wr_data = pat(i);
            step();
        end
        wr_en = 1'b0;
        step();

        // R8: integer and floating-point entries are separate
        raddr_a = 6'd3; raddr_c = 6'd35;
        step();
        chk(rdata_a === pat(3), "R8 entry 3", rdata_a, pat(3));
        chk(rdata_c === pat(35), "R8 entry 35", rdata_c, pat(35));

        // R1: registered read, outputs hold between edges
        raddr_a = 6'd2;
        step();
        chk(rdata_a === pat(2), "R1 read one edge later", rdata_a, pat(2));
        raddr_a = 6'd4;
        #1;
        chk(rdata_a === pat(2), "R1 no combinational path", rdata_a, pat(2));
        step();
        chk(rdata_a === pat(4), "R1 next read", rdata_a, pat(4));

        // R3: same-cycle write and read
        wr_en = 1'b1; wr_idx = 6'd10; wr_data = 64'hDEAD_BEEF_0000_0010; raddr_a = 6'd10;
        step();
        wr_en = 1'b0;
        chk(rdata_a === 64'hDEAD_BEEF_0000_0010, "R3 forwarded write", rdata_a, 64'hDEAD_BEEF_0000_0010);

        // R2: read in the cycle after a write
        dec_valid = 1'b1; dec_uses_b = 1'b1;
        wr_en = 1'b1; wr_idx = 6'd11; wr_data = 64'h1234_5678_9ABC_0011;
        step();
        wr_en = 1'b0; raddr_b = 6'd11;
        step();
        chk(rdata_b === 64'h1234_5678_9ABC_0011, "R2 read after write", rdata_b, 64'h1234_5678_9ABC_0011);

        // R4: stall reuses held index
        raddr_a = 6'd12;
        step();
        chk(rdata_a === pat(12), "R4 before stall", rdata_a, pat(12));
        stall = 1'b1; raddr_a = 6'd13;
        step();
        chk(rdata_a === pat(12), "R4 held index", rdata_a, pat(12));
        wr_en = 1'b1; wr_idx = 6'd12; wr_data = 64'h0BAD_F00D_0000_0012;
        step();
        wr_en = 1'b0;
        chk(rdata_a === 64'h0BAD_F00D_0000_0012, "R4 forwarded during stall", rdata_a, 64'h0BAD_F00D_0000_0012);
        stall = 1'b0;
        step();
        chk(rdata_a === pat(13), "R4 released", rdata_a, pat(13));

        // R5/R6/R9: debug held off while B is busy
        raddr_b = 6'd20; raddr_a = 6'd21;
        dbg_req = 1'b1; dbg_idx = 6'd40;
        step();
        dbg_req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(dbg_done === 1'b0, "R5 held off by B use", DW'(dbg_done), '0);
            chk(rdata_b === pat(20), "R5 B keeps pipeline data", rdata_b, pat(20));
            if (k == 1) begin dbg_req = 1'b1; dbg_idx = 6'd41; end
            step();
            dbg_req = 1'b0;
        end
        dec_uses_b = 1'b0;
        step();
        chk(dbg_done === 1'b1, "R6 done after free", DW'(dbg_done), 64'd1);
        chk(dbg_data === pat(40), "R6 debug data", dbg_data, pat(40));
        chk(rdata_a === pat(21), "R9 port A during steal", rdata_a, pat(21));
        step();
        chk(dbg_done === 1'b0, "R6 single strobe", DW'(dbg_done), '0);

        // R5: stall also blocks debug
        dec_valid = 1'b0; stall = 1'b1; dbg_req = 1'b1; dbg_idx = 6'd50;
        step();
        dbg_req = 1'b0;
        chk(dbg_done === 1'b0, "R5 blocked by stall", DW'(dbg_done), '0);
        stall = 1'b0;
        step();
        chk(dbg_done === 1'b1, "R6 done after stall", DW'(dbg_done), 64'd1);
        chk(dbg_data === pat(50), "R6 debug data after stall", dbg_data, pat(50));

        // mixed traffic checked against the model
        for (int t = 0; t < 3000; t++) begin
            stall      = ($urandom % 4) == 0;
            dec_valid  = ($urandom % 3) != 0;
            dec_uses_b = ($urandom % 2) == 0;
            raddr_a    = IW'($urandom);
            raddr_b    = IW'($urandom);
            raddr_c    = IW'($urandom);
            wr_en      = ($urandom % 2) == 0;
            wr_idx     = ($urandom % 3 == 0) ? raddr_a : IW'($urandom);
            wr_data    = {$urandom, $urandom};
            dbg_req    = ($urandom % 8) == 0;
            dbg_idx    = IW'($urandom);
            step();
        end
        stall = 1'b0; wr_en = 1'b0; dbg_req = 1'b0;
        repeat (4) step();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule